// File: doc/BRIEF.md
# Receive Packet Length Limiter

This block sits in the receive byte path of a DMA channel, between the link and the memory writer. It counts the bytes of every packet against a programmable maximum length. Bytes within the limit pass to the writer unchanged, with their handshake. Once the limit is reached, every later byte of the same packet is accepted from upstream and thrown away, up to and including the end-of-packet byte, so the link never stalls on an oversized packet. One cycle after the end-of-packet byte is accepted, a status pulse gives the number of bytes that were forwarded and whether the packet was cut short.

The limit is set through a write strobe and a value. Its two low bits are cleared when it is written, so the limit is always a whole number of 32-bit words. A limit of zero disables the channel: every byte is drained and every packet is reported as truncated with a count of zero.

The control is a two-state machine. In `RXL_FWD` a byte is forwarded while the count is below the limit. At the limit the byte is spilled instead; the machine stays in `RXL_FWD` if that byte ends the packet. A spilled byte that does not end the packet moves the machine to `RXL_DRAIN`. `RXL_DRAIN` accepts and discards bytes, and returns to `RXL_FWD` when the end-of-packet byte is accepted. Every end of packet clears the count.

Top module: `rx_len_limiter`

## Requirements
- R1: After reset, the status output is idle, the output stream is not valid, and the limit is zero. A packet sent before any write is drained and reported with count 0 and truncation set.
- R2: A write stores the written value with bits [1:0] forced to 0, and the new limit applies from the next cycle. A write of 7 gives a limit of 4. A write of 0x1FFFFFF gives 33554428. Without a write the limit does not change.
- R3: While fewer bytes than the limit have been accepted in the current packet, the input byte is presented at the output with the same data and end-of-packet flag, and the input ready equals the output ready.
- R4: A packet of at most limit bytes produces a status with count equal to its length and truncation clear.
- R5: Once limit bytes of a packet have been accepted, every later byte of that packet is consumed with input ready high, whatever the output ready is, and the output valid stays low.
- R6: A packet longer than the limit produces a status with count equal to the limit and truncation set. This includes a packet exactly one byte longer than the limit.
- R7: With a limit of zero, no byte is forwarded and every packet reports count 0 with truncation set.
- R8: The status valid is high for exactly the one cycle after each accepted end-of-packet byte, and low in every other cycle. Back-to-back one-byte packets give one pulse per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Limit write strobe |
| cfg_len | input | LEN_W | Limit value in bytes (bits [1:0] ignored) |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | DATA_W | Input byte |
| s_eop | input | 1 | Input byte is the last of its packet |
| m_valid | output | 1 | Forwarded byte valid |
| m_ready | input | 1 | Memory writer can take a byte |
| m_data | output | DATA_W | Forwarded byte |
| m_eop | output | 1 | Forwarded byte is the last of its packet |
| st_valid | output | 1 | Status pulse, one cycle after packet end |
| st_count | output | LEN_W | Bytes forwarded for the packet |
| st_trunc | output | 1 | Packet was longer than the limit |

## Verification
The hardest case to reach is the packet whose end-of-packet byte arrives exactly when the count equals the limit. There the machine must report truncation without ever entering `RXL_DRAIN`. Next to it is the spill phase under writer backpressure, where the input ready must ignore the output ready. Directed packets of limit+1 bytes, including one-byte packets at limit zero, hit the first case. Random packet lengths against small random limits, with random output-ready stalls and input gaps, cover the drain phase with the writer both stalled and free.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
    typedef enum logic {
        RXL_FWD   = 1'b0,
        RXL_DRAIN = 1'b1
    } rxl_state_e;
endpackage

// File: rtl/rxl_len_reg.sv
module rxl_len_reg #(
    parameter int LEN_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] lim
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim <= '0;
        end else if (wr_en) begin
            lim <= {wr_len[LEN_W-1:2], 2'b00};
        end
    end

    // R2
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lim));
endmodule

// File: rtl/rxl_status_reg.sv
module rxl_status_reg #(
    parameter int LEN_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [LEN_W-1:0] done_cnt,
    input  logic             done_trunc,
    output logic             st_valid,
    output logic [LEN_W-1:0] st_count,
    output logic             st_trunc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_count <= '0;
            st_trunc <= 1'b0;
        end else begin
            st_valid <= done;
            if (done) begin
                st_count <= done_cnt;
                st_trunc <= done_trunc;
            end
        end
    end
endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter
    import rxl_pkg::*;
#(
    parameter int LEN_W  = 25,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_eop,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_eop,
    output logic              st_valid,
    output logic [LEN_W-1:0]  st_count,
    output logic              st_trunc
);
    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    rxl_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] lim;
    logic             below_lim;
    logic             fire;
    logic             done;
    logic [LEN_W-1:0] done_cnt;
    logic             done_trunc;

    rxl_len_reg #(.LEN_W(LEN_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_len (cfg_len),
        .lim    (lim)
    );

    assign below_lim = (cnt_q < lim);
    assign fire      = s_valid && s_ready;
    assign m_data    = s_data;

    // Output decode
    always_comb begin
        m_valid = 1'b0;
        s_ready = 1'b1;
        unique case (state_q)
            RXL_FWD: begin
                if (below_lim) begin
                    m_valid = s_valid;
                    s_ready = m_ready;
                end
            end
            RXL_DRAIN: begin
                m_valid = 1'b0;
                s_ready = 1'b1;
            end
        endcase
        m_eop = s_eop && m_valid;
    end

    // Next state, count and packet end
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        done       = 1'b0;
        done_cnt   = cnt_q;
        done_trunc = 1'b0;
        unique case (state_q)
            RXL_FWD: begin
                if (fire) begin
                    if (below_lim) begin
                        if (s_eop) begin
                            done     = 1'b1;
                            done_cnt = cnt_q + CNT_ONE;
                            cnt_d    = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_ONE;
                        end
                    end else if (s_eop) begin
                        done       = 1'b1;
                        done_trunc = 1'b1;
                        cnt_d      = '0;
                    end else begin
                        state_d = RXL_DRAIN;
                    end
                end
            end
            RXL_DRAIN: begin
                if (fire && s_eop) begin
                    done       = 1'b1;
                    done_trunc = 1'b1;
                    cnt_d      = '0;
                    state_d    = RXL_FWD;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RXL_FWD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    rxl_status_reg #(.LEN_W(LEN_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .done_cnt   (done_cnt),
        .done_trunc (done_trunc),
        .st_valid   (st_valid),
        .st_count   (st_count),
        .st_trunc   (st_trunc)
    );

    // R8
    st_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(s_valid && s_ready && s_eop));

    // R6
    trunc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_trunc) |-> (st_count == lim));

    // R4
    clean_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_trunc) |-> (st_count <= lim && st_count != '0));

    // R5
    spill_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_eop && !m_valid) |=> s_ready);

    // R3
    fwd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (s_ready == m_ready));
endmodule

// File: tb/tb_rx_len_limiter.sv
module tb_rx_len_limiter;
    localparam int LEN_W  = 25;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_eop = 1'b0;
    logic              m_valid;
    logic              m_ready = 1'b0;
    logic [DATA_W-1:0] m_data;
    logic              m_eop;
    logic              st_valid;
    logic [LEN_W-1:0]  st_count;
    logic              st_trunc;

    rx_len_limiter #(.LEN_W(LEN_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_eop(s_eop),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_eop(m_eop),
        .st_valid(st_valid), .st_count(st_count), .st_trunc(st_trunc)
    );

    always #10 clk = ~clk;

    int          vecs = 0;
    int          errs = 0;
    int unsigned lim_m = 0;
    logic        pend = 1'b0;
    int unsigned pend_cnt = 0;
    logic        pend_tr = 1'b0;
    string       pend_tag = "";

    function automatic int unsigned exp_count(int unsigned len, int unsigned lim);
        return (len <= lim) ? len : lim;
    endfunction

    function automatic string status_tag(string t, int unsigned len, int unsigned lim);
        if (t != "") return t;
        if (lim == 0) return "R7";
        return (len > lim) ? "R6" : "R4";
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_status();
        if (pend) begin
            chk(pend_tag, "st_valid", st_valid, 1);
            chk(pend_tag, "st_count", st_count, pend_cnt);
            chk(pend_tag, "st_trunc", st_trunc, pend_tr);
            pend = 1'b0;
        end else begin
            chk("R8", "st_valid idle", st_valid, 0);
        end
    endtask

    task automatic set_len(int unsigned v);
        @(negedge clk);
        chk_status();
        s_valid = 1'b0;
        cfg_we  = 1'b1;
        cfg_len = LEN_W'(v);
        @(negedge clk);
        chk_status();
        cfg_we  = 1'b0;
        lim_m   = v & ~32'd3;
    endtask

    task automatic idle();
        @(negedge clk);
        chk_status();
        s_valid = 1'b0;
    endtask

    task automatic send_pkt(int unsigned len, int unsigned gap_pct,
                            int unsigned bp_pct, string tag);
        int unsigned i = 0;
        while (i < len) begin
            logic v;
            logic exp_f;
            @(negedge clk);
            chk_status();
            v       = (($urandom % 100) >= gap_pct);
            s_valid = v;
            s_data  = DATA_W'($urandom);
            s_eop   = (i == len - 1);
            m_ready = (($urandom % 100) >= bp_pct);
            #2;
            exp_f = (i < lim_m);
            chk(exp_f ? "R3" : "R5", "m_valid", m_valid, v && exp_f);
            if (v && exp_f) begin
                chk("R3", "m_data", m_data, s_data);
                chk("R3", "m_eop", m_eop, s_eop);
            end
            chk(exp_f ? "R3" : "R5", "s_ready", s_ready, exp_f ? m_ready : 1'b1);
            if (v && s_ready) begin
                if (s_eop) begin
                    pend     = 1'b1;
                    pend_cnt = exp_count(len, lim_m);
                    pend_tr  = (len > lim_m);
                    pend_tag = status_tag(tag, len, lim_m);
                end
                i++;
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "st_valid", st_valid, 0);
        chk("R1", "m_valid", m_valid, 0);
        chk("R1", "s_ready (disabled)", s_ready, 1);
        send_pkt(3, 0, 0, "R1");
        idle();
        // R2 alignment: 7 -> 4
        set_len(7);
        send_pkt(6, 0, 0, "R2");
        send_pkt(4, 0, 0, "R2");
        idle();
        // R7 zero limit
        set_len(0);
        send_pkt(5, 0, 50, "R7");
        send_pkt(1, 0, 0, "R7");
        idle();
        // R4 / R6 corners
        set_len(8);
        send_pkt(1, 0, 0, "R4");
        send_pkt(8, 0, 40, "R4");
        send_pkt(9, 0, 40, "R6");
        send_pkt(30, 10, 60, "R6");
        // R8 back-to-back single-byte packets
        for (int k = 0; k < 6; k++) send_pkt(1, 0, 0, "R8");
        idle();
        // R2 largest value
        set_len(32'h1FFFFFF);
        send_pkt(20, 0, 0, "R2");
        idle();
        // random traffic
        for (int n = 0; n < 200; n++) begin
            if (($urandom % 4) == 0) set_len(($urandom % 16) * 4 + ($urandom % 4));
            send_pkt(1 + ($urandom % 70), 20, 30, "");
        end
        idle();
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule